// File: doc/BRIEF.md
# Head-Positioner Range Fault Monitor

This block watches a disk head positioner while the heads load and afterwards. It arms itself on the first index pulse from the position transducer during head load. The arming event is the falling edge of that pulse, seen while no restore operation is running. Once armed, any high level on the transducer index means the positioner has left its legal travel. A high level on the heads-retract signal counts as a fault in the same way. Either fault drives an active-low range error and latches an emergency-unload request.

All five control inputs arrive asynchronously and each passes through a synchronizer of configurable depth. The monitor disarms and drops its unload request whenever the purge-cycle flag and the load-heads flag are both low. This covers a drive that is not running, and a drive that is running but has not reached its purge cycle. A second index pulse during load is therefore caught at once, before loading completes.

Top module: `pos_range_monitor`

## Requirements
- R1: While the synchronized purge flag and load flag are both 0, the arm flag is cleared and the unload request is 0. The two flags are the clear condition.
- R2: With the clear released, a 1-to-0 transition of the synchronized index input while restore is 0 sets the arm flag one clock after the synchronized transition.
- R3: A rising edge or a steady level of index does not arm the monitor. While restore is 1, index transitions do not arm it either.
- R4: Once set, the arm flag stays 1 until the clear condition returns.
- R5: While armed, a high synchronized index drives limit_err_no to 0. While not armed, index has no effect on limit_err_no.
- R6: While armed, a high synchronized retract drives limit_err_no to 0. While not armed, retract has no effect on limit_err_no or unload_o.
- R7: A fault (limit_err_no at 0 with the clear released) sets unload_o on the next clock edge. unload_o then stays 1 until the clear condition returns, even after the fault goes away.
- R8: A second index pulse while the load flag is still 1 produces limit_err_no at 0 and unload_o at 1.
- R9: After an index input rises while armed, limit_err_no falls exactly SYNC_STAGES clock edges later. unload_o rises exactly one edge after that.
- R10: During and right after reset, armed_o is 0, limit_err_no is 1 and unload_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| index_i | input | 1 | Position-transducer index, asynchronous |
| retract_i | input | 1 | Heads-retract indication, asynchronous |
| restore_i | input | 1 | Restore operation in progress, asynchronous |
| purge_i | input | 1 | Purge-cycle sequencer flag, asynchronous |
| load_i | input | 1 | Load-heads sequencer flag, asynchronous |
| armed_o | output | 1 | Monitor armed |
| limit_err_no | output | 1 | Position-limit error, active low |
| unload_o | output | 1 | Emergency-unload request, held |

## Verification
The bench builds the monitor with SYNC_STAGES set to 3 rather than the default 2. This makes the exact-latency checks of R9 depend on the parameter instead of a fixed two-flop path. The random phase holds each input pattern for longer than the full synchronizer-plus-register path. A settled model of arm, fault and unload can then be compared after every step. This reaches restore masking, a restore-induced falling edge of the trigger, and clears that arrive during a fault.

// File: rtl/pos_mon_pkg.sv
package pos_mon_pkg;
  typedef struct packed {
    logic idx;
    logic ret;
    logic rest;
    logic purge;
    logic load;
  } mon_in_t;
  localparam int unsigned IN_W = $bits(mon_in_t);
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pm_arm.sv
module pm_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trig_i,
  output logic armed_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  // set input is constant one: any falling trigger edge sets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_o <= 1'b0;
    else if (clr_i)             armed_o <= 1'b0;
    else if (trig_q && !trig_i) armed_o <= 1'b1;
  end
endmodule

// File: rtl/pm_fault.sv
module pm_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic armed_i,
  input  logic idx_i,
  input  logic ret_i,
  output logic err_no,
  output logic unload_o
);
  logic fault;

  assign fault  = armed_i && (idx_i || ret_i);
  assign err_no = !fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    unload_o <= 1'b0;
    else if (clr_i) unload_o <= 1'b0;
    else if (fault) unload_o <= 1'b1;
  end
endmodule

// File: rtl/pos_range_monitor.sv
module pos_range_monitor
  import pos_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic index_i,
  input  logic retract_i,
  input  logic restore_i,
  input  logic purge_i,
  input  logic load_i,
  output logic armed_o,
  output logic limit_err_no,
  output logic unload_o
);
  mon_in_t raw, syn;
  logic    clr_s, trig_s;
  logic    idx_s, ret_s, rest_s, purge_s, load_s;

  assign raw = '{idx: index_i, ret: retract_i, rest: restore_i,
                 purge: purge_i, load: load_i};

  pm_sync #(.STAGES(SYNC_STAGES), .W(IN_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign idx_s   = syn.idx;
  assign ret_s   = syn.ret;
  assign rest_s  = syn.rest;
  assign purge_s = syn.purge;
  assign load_s  = syn.load;

  assign clr_s  = !purge_s && !load_s;
  assign trig_s = idx_s && !rest_s;

  pm_arm u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_s),
    .trig_i (trig_s),
    .armed_o(armed_o)
  );

  pm_fault u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_s),
    .armed_i (armed_o),
    .idx_i   (idx_s),
    .ret_i   (ret_s),
    .err_no  (limit_err_no),
    .unload_o(unload_o)
  );
endmodule

// File: rtl/pos_range_monitor_chk.sv
module pos_range_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic idx_s,
  input logic ret_s,
  input logic rest_s,
  input logic purge_s,
  input logic load_s,
  input logic armed_o,
  input logic limit_err_no,
  input logic unload_o
);
  logic run, trg;
  assign run = purge_s || load_s;
  assign trg = idx_s && !rest_s;

  AST_CLEAR_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (!armed_o && !unload_o)); // R1
  AST_ARM_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $fell(trg)) |=> armed_o); // R2
  AST_NO_SPURIOUS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !$fell(trg)) |=> !armed_o); // R3
  AST_ARM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && run) |=> armed_o); // R4
  AST_ERR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !limit_err_no |-> (armed_o && (idx_s || ret_s))); // R5
  AST_RETRACT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && ret_s) |-> !limit_err_no); // R6
  AST_UNLOAD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!limit_err_no && run) |=> unload_o); // R7
  AST_UNLOAD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unload_o && run) |=> unload_o); // R7
endmodule

bind pos_range_monitor pos_range_monitor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .idx_s       (idx_s),
  .ret_s       (ret_s),
  .rest_s      (rest_s),
  .purge_s     (purge_s),
  .load_s      (load_s),
  .armed_o     (armed_o),
  .limit_err_no(limit_err_no),
  .unload_o    (unload_o)
);

// File: tb/tb_pos_range_monitor.sv
`timescale 1ns/1ps
module tb_pos_range_monitor;
  localparam int unsigned STAGES = 3;
  localparam int unsigned HOLD   = STAGES + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idx = 0, ret = 0, rest = 0, purge = 0, load = 0;
  logic armed, err_n, unl;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  bit m_trig = 0, m_arm = 0, m_unl = 0, m_flt = 0;

  always #10 clk = ~clk;

  pos_range_monitor #(.SYNC_STAGES(STAGES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .index_i(idx), .retract_i(ret),
    .restore_i(rest), .purge_i(purge), .load_i(load),
    .armed_o(armed), .limit_err_no(err_n), .unload_o(unl)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // settled-state model from the requirements
  task automatic apply(bit i, bit r, bit rs, bit pu, bit ld, int hold = HOLD);
    bit t, clr;
    @(negedge clk);
    {idx, ret, rest, purge, load} = {i, r, rs, pu, ld};
    t   = i && !rs;
    clr = !pu && !ld;
    if (clr)                m_arm = 0;
    else if (m_trig && !t)  m_arm = 1;
    m_trig = t;
    m_flt  = m_arm && (i || r);
    if (clr)        m_unl = 0;
    else if (m_flt) m_unl = 1;
    repeat (hold) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    chk({req, " armed"}, armed, m_arm);
    chk({req, " err_n"}, err_n, !m_flt);
    chk({req, " unload"}, unl, m_unl);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk("R10 reset armed", armed, 1'b0);
    chk("R10 reset err", err_n, 1'b1);
    chk("R10 reset unload", unl, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R10 after reset err", err_n, 1'b1);

    // R1: index pulse with clear held does not arm
    apply(1, 0, 0, 0, 0); apply(0, 0, 0, 0, 0); check_all("R1 clear held");
    // R3: rising edge and level do not arm
    apply(0, 0, 0, 0, 1); apply(1, 0, 0, 0, 1); check_all("R3 rise only");
    chk("R5 unarmed index no err", err_n, 1'b1);
    // R2: falling edge arms
    apply(0, 0, 0, 0, 1); check_all("R2 fall arms");
    chk("R2 armed", armed, 1'b1);
    // R8: second index pulse during load
    apply(1, 0, 0, 0, 1); check_all("R8 second pulse");
    chk("R8 err low", err_n, 1'b0);
    chk("R8 unload", unl, 1'b1);
    apply(0, 0, 0, 0, 1); check_all("R7 unload sticky");
    chk("R7 sticky", unl, 1'b1);
    // R4: armed holds through purge while load drops
    apply(0, 0, 0, 1, 0); check_all("R4 hold");
    chk("R4 armed hold", armed, 1'b1);
    apply(0, 0, 0, 0, 0); check_all("R1 clear returns");
    chk("R1 unload cleared", unl, 1'b0);
    // R3: restore masks index
    apply(0, 0, 1, 0, 1); apply(1, 0, 1, 0, 1); apply(0, 0, 1, 0, 1);
    check_all("R3 restore mask");
    chk("R3 not armed", armed, 1'b0);
    // R6: retract unarmed ignored, armed faults
    apply(0, 1, 0, 0, 1); check_all("R6 unarmed retract");
    chk("R6 unarmed unload", unl, 1'b0);
    apply(1, 0, 0, 0, 1); apply(0, 0, 0, 0, 1);
    apply(0, 1, 0, 0, 1); check_all("R6 armed retract");
    chk("R6 err low", err_n, 1'b0);
    apply(0, 0, 0, 0, 0);

    // R9: exact latency
    apply(0, 0, 0, 0, 1); apply(1, 0, 0, 0, 1); apply(0, 0, 0, 0, 1);
    @(negedge clk) idx = 1'b1;
    repeat (STAGES - 1) @(posedge clk);
    @(negedge clk);
    chk("R9 err before latency", err_n, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 err at latency", err_n, 1'b0);
    chk("R9 unload not yet", unl, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9 unload one later", unl, 1'b1);
    apply(1, 0, 0, 0, 1); apply(0, 0, 0, 0, 0);

    // random phase, R1-style clear mixed with load/purge activity
    for (int k = 0; k < 400; k++) begin
      bit pu, ld;
      pu = ($urandom % 4) == 0;
      ld = ($urandom % 8) != 0;
      apply($urandom % 2, ($urandom % 6) == 0, ($urandom % 5) == 0, pu, ld);
      check_all("R2 R5 R7 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule